// File: doc/BRIEF.md
# Two-wire DAC command slave

This block sits on a two-wire (I2C-compatible) bus as a slave and holds the programmed state of one DAC channel: an output code and a two-bit power-down mode. It samples SCL and SDA with the system clock and recognises START and STOP from those samples. It answers a 7-bit address whose upper bits are fixed and whose lowest one or two bits come from strap pins. It drives SDA only as an open-drain pull-down, through `sda_oe`.

A write transfer carries 16-bit command words, high byte first. The slave keeps the first byte of each pair and commits the full word to the output registers when the second byte arrives. The master can keep writing pairs after a single address phase, and each completed pair changes the outputs again. A read transfer returns the last committed word, high byte first. If the master acknowledges the low byte, the slave starts again from the high byte. The master ends a read by not acknowledging.

Top module: `i2c_dac_slave`

## Requirements
- R1: After reset `dac_code` is all zeros, `dac_mode` is 2'b00 (normal operation) and `sda_oe` is 0.
- R2: SDA falling while SCL is high is a START and starts address matching. SDA rising while SCL is high is a STOP. After a STOP, `sda_oe` is 0 and the slave ignores all traffic until the next START.
- R3: The first byte after START carries the address in bits 7:1, MSB first, and the read flag in bit 0 (1 = read). With ADDR_PINS = 2 the address is {5'b00011, addr_pins[1:0]}. With ADDR_PINS = 1 it is {6'b000110, addr_pins[0]}. On a match the slave pulls SDA low for the ninth clock. On a mismatch it never drives SDA and ignores every byte until the next START.
- R4: During a write, the slave pulls SDA low on the ninth clock of every data byte.
- R5: A command word is the first data byte of a pair (bits 15:8) followed by the second (bits 7:0). Bits 13:12 become `dac_mode`. Bits 11:(12-DATA_W) become `dac_code`, left-justified. Bits 15:14 and the bits below the code have no effect on either output. The outputs change only when the second byte of a pair has been received.
- R6: Each further pair of data bytes in the same addressed write commits a new word, with no new address phase.
- R7: A single data byte followed by STOP leaves `dac_code` and `dac_mode` unchanged, and the next write starts a new pair.
- R8: A read returns the last committed word, high byte then low byte, MSB first. It wraps back to the high byte if the master acknowledges the low byte. After the master does not acknowledge, the slave releases SDA and sends nothing more.
- R9: A START or STOP in the middle of a byte aborts the transfer and discards any half-received pair. A START while addressed acts as a repeated START, so a read can follow a write without a STOP.
- R10: `sda_oe` changes only in the cycle after a detected SCL falling edge, START or STOP, so the slave never moves SDA while SCL is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock used to oversample the bus |
| rst_n | input | 1 | Asynchronous active-low reset |
| scl_i | input | 1 | Bus clock line |
| sda_i | input | 1 | Bus data line as seen on the wire |
| sda_oe | output | 1 | 1 pulls SDA low (open-drain enable) |
| addr_pins | input | ADDR_PINS | Strap pins giving the low address bits |
| dac_code | output | DATA_W | Committed DAC code |
| dac_mode | output | 2 | Committed power-down mode, 00 = normal |

## Verification
The hardest case to reach from the pins is a half-received command pair that is thrown away. This happens when the bus breaks off after one data byte, or in the middle of a byte, and the next transfer must not reuse the stale high byte. To reach it, the bench stops bit-banging partway through a byte and issues a START or STOP there. It then writes a fresh pair whose mode and code fields differ from both the stale byte and the previous word, so that any leftover byte shows up directly on `dac_mode` and `dac_code`.

// File: rtl/i2c_dac_pkg.sv
package i2c_dac_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_ADDR,
        ST_AACK,
        ST_WBYTE,
        ST_WACK,
        ST_RBYTE,
        ST_RACK
    } st_e;

    typedef struct packed {
        st_e        st;
        logic [3:0] cnt;
        logic [7:0] sh;
        logic [7:0] hi;
        logic       ph;
        logic       rw;
        logic       oe;
        logic       mack;
    } fsm_s;

    localparam int WORD_W = 16;

endpackage

// File: rtl/i2c_line_monitor.sv
module i2c_line_monitor (
    input  logic clk,
    input  logic rst_n,
    input  logic scl_i,
    input  logic sda_i,
    output logic sda_s,
    output logic scl_rise,
    output logic scl_fall,
    output logic start_det,
    output logic stop_det
);
    typedef struct packed {
        logic [1:0] scl_sy;
        logic [1:0] sda_sy;
        logic       scl_p;
        logic       sda_p;
    } mon_s;

    mon_s q, d;

    always_comb begin
        d        = q;
        d.scl_sy = {q.scl_sy[0], scl_i};
        d.sda_sy = {q.sda_sy[0], sda_i};
        d.scl_p  = q.scl_sy[1];
        d.sda_p  = q.sda_sy[1];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '1;
        else        q <= d;
    end

    assign sda_s     = q.sda_sy[1];
    assign scl_rise  =  q.scl_sy[1] & ~q.scl_p;
    assign scl_fall  = ~q.scl_sy[1] &  q.scl_p;
    assign start_det =  q.scl_sy[1] & q.scl_p &  q.sda_p & ~q.sda_sy[1];
    assign stop_det  =  q.scl_sy[1] & q.scl_p & ~q.sda_p &  q.sda_sy[1];
endmodule

// File: rtl/dac_word_reg.sv
module dac_word_reg
    import i2c_dac_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [WORD_W-1:0] wr_word,
    output logic [WORD_W-1:0] word_q
);
    logic [WORD_W-1:0] word_d;

    always_comb begin
        word_d = word_q;
        if (wr_en) word_d = wr_word;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) word_q <= '0;
        else        word_q <= word_d;
    end
endmodule

// File: rtl/i2c_dac_slave.sv
module i2c_dac_slave
    import i2c_dac_pkg::*;
#(
    parameter int DATA_W    = 12,
    parameter int ADDR_PINS = 2
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 scl_i,
    input  logic                 sda_i,
    output logic                 sda_oe,
    input  logic [ADDR_PINS-1:0] addr_pins,
    output logic [DATA_W-1:0]    dac_code,
    output logic [1:0]           dac_mode
);
    localparam int CODE_LSB = 12 - DATA_W;

    logic              sda_s, mon_rise, mon_fall, mon_start, mon_stop;
    logic              commit;
    logic [WORD_W-1:0] word_q;
    logic [6:0]        my_addr;
    fsm_s              q, d;

    generate
        if (ADDR_PINS == 1) begin : g_one_pin
            assign my_addr = {6'b000110, addr_pins[0]};
        end else begin : g_two_pin
            assign my_addr = {5'b00011, addr_pins[1:0]};
        end
    endgenerate

    i2c_line_monitor u_mon (
        .clk       (clk),
        .rst_n     (rst_n),
        .scl_i     (scl_i),
        .sda_i     (sda_i),
        .sda_s     (sda_s),
        .scl_rise  (mon_rise),
        .scl_fall  (mon_fall),
        .start_det (mon_start),
        .stop_det  (mon_stop)
    );

    dac_word_reg u_word (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (commit),
        .wr_word ({q.hi, q.sh}),
        .word_q  (word_q)
    );

    always_comb begin
        d      = q;
        commit = 1'b0;
        if (mon_stop) begin
            d.st = ST_IDLE;
            d.oe = 1'b0;
        end else if (mon_start) begin
            d.st  = ST_ADDR;
            d.cnt = '0;
            d.oe  = 1'b0;
            d.ph  = 1'b0;
        end else begin
            case (q.st)
                ST_ADDR: begin
                    if (mon_rise) begin
                        d.sh  = {q.sh[6:0], sda_s};
                        d.cnt = q.cnt + 4'd1;
                    end else if (mon_fall && q.cnt == 4'd8) begin
                        if (q.sh[7:1] == my_addr) begin
                            d.st = ST_AACK;
                            d.oe = 1'b1;
                            d.rw = q.sh[0];
                            d.ph = 1'b0;
                        end else begin
                            d.st = ST_IDLE;
                        end
                    end
                end
                ST_AACK: begin
                    if (mon_fall) begin
                        d.cnt = '0;
                        if (q.rw) begin
                            d.sh = word_q[15:8];
                            d.ph = 1'b1;
                            d.oe = ~word_q[15];
                            d.st = ST_RBYTE;
                        end else begin
                            d.oe = 1'b0;
                            d.st = ST_WBYTE;
                        end
                    end
                end
                ST_WBYTE: begin
                    if (mon_rise) begin
                        d.sh  = {q.sh[6:0], sda_s};
                        d.cnt = q.cnt + 4'd1;
                    end else if (mon_fall && q.cnt == 4'd8) begin
                        d.oe = 1'b1;
                        d.st = ST_WACK;
                        if (!q.ph) begin
                            d.hi = q.sh;
                            d.ph = 1'b1;
                        end else begin
                            commit = 1'b1;
                            d.ph   = 1'b0;
                        end
                    end
                end
                ST_WACK: begin
                    if (mon_fall) begin
                        d.oe  = 1'b0;
                        d.cnt = '0;
                        d.st  = ST_WBYTE;
                    end
                end
                ST_RBYTE: begin
                    if (mon_fall) begin
                        if (q.cnt == 4'd7) begin
                            d.oe = 1'b0;
                            d.st = ST_RACK;
                        end else begin
                            d.sh  = {q.sh[6:0], 1'b0};
                            d.oe  = ~q.sh[6];
                            d.cnt = q.cnt + 4'd1;
                        end
                    end
                end
                ST_RACK: begin
                    if (mon_rise) begin
                        d.mack = ~sda_s;
                    end else if (mon_fall) begin
                        if (q.mack) begin
                            d.sh  = q.ph ? word_q[7:0] : word_q[15:8];
                            d.oe  = q.ph ? ~word_q[7] : ~word_q[15];
                            d.ph  = ~q.ph;
                            d.cnt = '0;
                            d.st  = ST_RBYTE;
                        end else begin
                            d.st = ST_IDLE;
                        end
                    end
                end
                default: d.st = ST_IDLE;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '{st: ST_IDLE, default: '0};
        else        q <= d;
    end

    assign sda_oe   = q.oe;
    assign dac_mode = word_q[13:12];
    assign dac_code = word_q[11:CODE_LSB];
endmodule

// File: rtl/i2c_dac_slave_chk.sv
module i2c_dac_slave_chk (
    input logic        clk,
    input logic        rst_n,
    input logic        sda_oe,
    input logic        scl_fall,
    input logic        start_det,
    input logic        stop_det,
    input logic        commit,
    input logic [15:0] word_q
);
    AST_WORD_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !commit |=> $stable(word_q)); // R5

    AST_STOP_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
        stop_det |=> !sda_oe); // R2

    AST_START_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
        start_det |=> !sda_oe); // R9

    AST_SDA_LOW_PHASE: assert property (@(posedge clk) disable iff (!rst_n)
        !(scl_fall || start_det || stop_det) |=> $stable(sda_oe)); // R10

    AST_COMMIT_ON_FALL: assert property (@(posedge clk) disable iff (!rst_n)
        commit |-> scl_fall); // R5
endmodule

bind i2c_dac_slave i2c_dac_slave_chk u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .sda_oe    (sda_oe),
    .scl_fall  (mon_fall),
    .start_det (mon_start),
    .stop_det  (mon_stop),
    .commit    (commit),
    .word_q    (word_q)
);

// File: tb/i2c_dac_slave_test.sv
`timescale 1ns/1ps
module i2c_dac_slave_test;
    localparam int Q = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        m_scl = 1'b1;
    logic        m_sda = 1'b1;
    logic        sda_oe;
    logic        sda_line;
    logic [1:0]  pins = 2'b00;
    logic [11:0] dac_code;
    logic [1:0]  dac_mode;
    int          errors = 0;
    int          checks = 0;
    logic        glitch = 1'b0;
    logic        done = 1'b0;

    always #2.5 clk = ~clk;

    assign sda_line = m_sda & ~sda_oe;

    i2c_dac_slave uut (
        .clk       (clk),
        .rst_n     (rst_n),
        .scl_i     (m_scl),
        .sda_i     (sda_line),
        .sda_oe    (sda_oe),
        .addr_pins (pins),
        .dac_code  (dac_code),
        .dac_mode  (dac_mode)
    );

    task automatic chk(input logic ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic wq();
        repeat (Q) @(negedge clk);
    endtask

    task automatic m_start();
        m_sda = 1'b1; wq();
        m_scl = 1'b1; wq();
        m_sda = 1'b0; wq();
        m_scl = 1'b0; wq();
    endtask

    task automatic m_stop();
        m_sda = 1'b0; wq();
        m_scl = 1'b1; wq();
        m_sda = 1'b1; wq();
    endtask

    task automatic m_bit(input logic b, output logic s);
        logic s2;
        m_sda = b; wq();
        m_scl = 1'b1; wq();
        s = sda_line; wq();
        s2 = sda_line;
        if (s2 != s) glitch = 1'b1;
        m_scl = 1'b0; wq();
    endtask

    task automatic m_wr(input logic [7:0] v, output logic acked);
        logic s;
        for (int i = 7; i >= 0; i--) m_bit(v[i], s);
        m_bit(1'b1, s);
        acked = ~s;
    endtask

    task automatic m_rd(input logic ack, output logic [7:0] v);
        logic s;
        for (int i = 7; i >= 0; i--) begin
            m_bit(1'b1, s);
            v[i] = s;
        end
        m_bit(~ack, s);
    endtask

    task automatic chk_out(input string req, input int code, input int mode);
        chk(dac_code == code[11:0], req, dac_code, code);
        chk(dac_mode == mode[1:0], req, dac_mode, mode);
    endtask

    task automatic t_reset();
        chk_out("R1", 0, 0);
        chk(sda_oe == 1'b0, "R1", sda_oe, 0);
    endtask

    task automatic t_write_pair();
        logic a;
        m_start();
        m_wr(8'h18, a); chk(a, "R3 addr ack", a, 1);
        m_wr(8'h3A, a); chk(a, "R4", a, 1);
        chk_out("R5 before 2nd byte", 0, 0);
        m_wr(8'hBC, a); chk(a, "R4", a, 1);
        chk_out("R5", 12'hABC, 3);
        m_stop();
        chk(sda_oe == 1'b0, "R2 stop", sda_oe, 0);
    endtask

    task automatic t_repeat();
        logic a;
        m_start();
        m_wr(8'h18, a);
        m_wr(8'h12, a); m_wr(8'h34, a);
        chk_out("R6 first pair", 12'h234, 1);
        m_wr(8'hC5, a); m_wr(8'h67, a);
        chk_out("R6 second pair", 12'h567, 0);
        m_stop();
    endtask

    task automatic t_partial();
        logic a;
        m_start();
        m_wr(8'h18, a);
        m_wr(8'h2F, a);
        m_stop();
        chk_out("R7", 12'h567, 0);
        m_start();
        m_wr(8'h18, a);
        m_wr(8'h11, a); m_wr(8'h00, a);
        chk_out("R7 fresh pair", 12'h100, 1);
        m_stop();
    endtask

    task automatic t_mismatch();
        logic a;
        m_start();
        m_wr(8'h1A, a); chk(!a, "R3 mismatch nack", a, 0);
        m_wr(8'h3F, a); chk(!a, "R3 ignored byte", a, 0);
        m_wr(8'hFF, a); chk(!a, "R3 ignored byte", a, 0);
        m_stop();
        chk_out("R3 unchanged", 12'h100, 1);
    endtask

    task automatic t_read();
        logic a;
        logic [7:0] v;
        m_start();
        m_wr(8'h18, a);
        m_wr(8'h12, a); m_wr(8'h34, a);
        m_start();
        m_wr(8'h19, a); chk(a, "R9 repeated start read", a, 1);
        glitch = 1'b0;
        m_rd(1'b1, v); chk(v == 8'h12, "R8 high", v, 8'h12);
        m_rd(1'b1, v); chk(v == 8'h34, "R8 low", v, 8'h34);
        m_rd(1'b0, v); chk(v == 8'h12, "R8 wrap", v, 8'h12);
        chk(!glitch, "R10 stable while SCL high", glitch, 0);
        chk(sda_oe == 1'b0, "R8 release after nack", sda_oe, 0);
        m_rd(1'b0, v); chk(v == 8'hFF, "R8 silent after nack", v, 8'hFF);
        m_stop();
    endtask

    task automatic t_abort();
        logic a;
        logic s;
        m_start();
        m_wr(8'h18, a);
        m_wr(8'h3F, a);
        for (int i = 0; i < 4; i++) m_bit(1'b1, s);
        m_start();
        m_wr(8'h18, a); chk(a, "R9 restart ack", a, 1);
        m_wr(8'h20, a); m_wr(8'h99, a);
        chk_out("R9 stale byte dropped", 12'h099, 2);
        m_wr(8'h1F, a);
        for (int i = 0; i < 3; i++) m_bit(1'b0, s);
        m_stop();
        chk_out("R9 mid-byte stop", 12'h099, 2);
    endtask

    initial begin
        repeat (5) @(negedge clk);
        rst_n = 1'b1;
        repeat (5) @(negedge clk);
        t_reset();
        t_write_pair();
        t_repeat();
        t_partial();
        t_mismatch();
        t_read();
        t_abort();
        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end
endmodule